// File: doc/BRIEF.md
# Processor Mode Register with Software Reset

This block is the processor mode control register of a small 16-bit microcontroller, mapped at one fixed byte address in the special-function register space. It holds the processor mode, the external-access wait control, the interrupt priority detection time and the clock-output enable. It decodes field values into ready-to-use control outputs for the rest of the chip.

One write-only bit of the register starts a software reset. The block then drives a synchronous reset pulse of fixed length to the core, the pins and the other special-function registers. The RAM-clear indication stays low, so internal RAM keeps its contents. When the pulse ends, and also after every hardware reset, the block reads the two reset-vector bytes over a simple request/acknowledge port. It then hands the assembled 16-bit start address to the core with a one-cycle strobe. A mode-select input pin holds one mode bit at 1 while it is high.

Top module: `sysmode_ctrl`

## Requirements
- R1: A read at REG_ADDR returns {0, clkout bit, ipd[1:0], 0, wait bit, mode[1:0]}. Bit 7 always reads 0, and a read elsewhere returns 0. After a hardware reset every field is 0, except mode bit 1 while `mode_pin` is high.
- R2: Writing a byte with bit 3 set to REG_ADDR starts a software reset, whatever the other bits hold. Bit 3 always reads as 0.
- R3: A software reset drives `core_rst` high for exactly PULSE_CYCLES cycles, starting on the edge that accepts the write. It returns all fields to their reset values.
- R4: While `mode_pin` is high, mode bit 1 reads as 1 and `proc_mode[1]` is 1. A write of 0 to that bit does not clear it.
- R5: `ram_clear` is high only during hardware reset (`hw_rst_n` low). It stays low throughout a software reset, so the RAM keeps its contents.
- R6: After any reset, the block requests the byte at VEC_ADDR and then the byte at VEC_ADDR+1. It holds `mem_req` and `mem_addr` steady until `mem_ack`, and `mem_req` is never high while `core_rst` is high.
- R7: `start_valid` is high for exactly one cycle, with `start_addr` = {byte at VEC_ADDR+1, byte at VEC_ADDR}.
- R8: `clkout_en` equals register bit 6, except when `proc_mode` is 2'b10 (microprocessor mode), where it is 0.
- R9: `ipd_cycles` decodes bits 5:4 as 00→7, 01→4 and 10→2. The reserved code 11 gives 7.
- R10: `ext_wait` is 1 when register bit 2 is 0, and 0 when bit 2 is 1.
- R11: Register writes made while the reset/fetch sequence is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| mode_pin | input | 1 | Mode-select pin; high holds mode bit 1 at 1 |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| core_rst | output | 1 | Reset to core, pins and SFRs (hardware or software) |
| ram_clear | output | 1 | RAM invalidate, hardware reset only |
| mem_req | output | 1 | Vector byte read request |
| mem_addr | output | 16 | Vector byte address |
| mem_rdata | input | 8 | Vector byte data, valid with mem_ack |
| mem_ack | input | 1 | Vector read acknowledge |
| start_addr | output | 16 | Assembled start address |
| start_valid | output | 1 | One-cycle start strobe |
| proc_mode | output | 2 | Effective processor mode |
| ext_wait | output | 1 | Insert wait on external accesses |
| ipd_cycles | output | 3 | Interrupt priority detection time in cycles |
| clkout_en | output | 1 | Clock output drives the shared pin |

## Verification
The bench builds the block with its default parameters: register address 0x5E, vector at 0xFFFE and a four-cycle pulse. These values give short reset windows, so many software resets fit into one run. Each reset gets fresh random vector bytes and a random acknowledge latency of zero to two cycles. This exercises the held request and byte ordering, while the RAM model's contents are compared after every reset. The mode pin toggles during the random register traffic, so its forcing is seen together with both microprocessor-mode gating and writes that try to clear the forced bit.

// File: rtl/sysmode_ctrl.sv
module sysmode_ctrl #(
  parameter logic [15:0] REG_ADDR     = 16'h005E,
  parameter logic [15:0] VEC_ADDR     = 16'hFFFE,
  parameter int          PULSE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        hw_rst_n,
  input  logic        mode_pin,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        core_rst,
  output logic        ram_clear,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  output logic [15:0] start_addr,
  output logic        start_valid,
  output logic [1:0]  proc_mode,
  output logic        ext_wait,
  output logic [2:0]  ipd_cycles,
  output logic        clkout_en
);
  localparam int          CNT_W  = $clog2(PULSE_CYCLES + 1);
  localparam logic [15:0] VEC_HI = VEC_ADDR + 16'd1;

  typedef enum logic [2:0] {ST_BOOT, ST_IDLE, ST_PULSE, ST_VLO, ST_VHI, ST_GO} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       mode_q;
  logic             nowait_q;
  logic [1:0]       ipd_q;
  logic             clk_q;
  logic [7:0]       vec_lo;

  logic sel, wr_hit, sw_rst;
  assign sel    = (bus_addr == REG_ADDR);
  assign wr_hit = bus_wr && sel && (st == ST_IDLE);
  assign sw_rst = wr_hit && bus_wdata[3];

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      st         <= ST_BOOT;
      cnt        <= '0;
      mode_q     <= 2'b00;
      nowait_q   <= 1'b0;
      ipd_q      <= 2'b00;
      clk_q      <= 1'b0;
      vec_lo     <= 8'h00;
      start_addr <= 16'h0000;
    end else begin
      case (st)
        ST_BOOT: st <= ST_VLO;
        ST_IDLE: begin
          if (sw_rst) begin
            st       <= ST_PULSE;
            cnt      <= CNT_W'(PULSE_CYCLES - 1);
            mode_q   <= 2'b00;
            nowait_q <= 1'b0;
            ipd_q    <= 2'b00;
            clk_q    <= 1'b0;
          end else if (wr_hit) begin
            mode_q   <= bus_wdata[1:0];
            nowait_q <= bus_wdata[2];
            ipd_q    <= bus_wdata[5:4];
            clk_q    <= bus_wdata[6];
          end
        end
        ST_PULSE: begin
          mode_q   <= 2'b00;
          nowait_q <= 1'b0;
          ipd_q    <= 2'b00;
          clk_q    <= 1'b0;
          if (cnt == '0) st <= ST_VLO;
          else           cnt <= cnt - 1'b1;
        end
        ST_VLO: if (mem_ack) begin
          vec_lo <= mem_rdata;
          st     <= ST_VHI;
        end
        ST_VHI: if (mem_ack) begin
          start_addr <= {mem_rdata, vec_lo};
          st         <= ST_GO;
        end
        ST_GO:   st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (mode_pin) mode_q[1] <= 1'b1;
    end
  end

  assign proc_mode   = {mode_q[1] | mode_pin, mode_q[0]};
  assign ext_wait    = ~nowait_q;
  assign clkout_en   = clk_q && (proc_mode != 2'b10);
  assign ipd_cycles  = (ipd_q == 2'b01) ? 3'd4 : (ipd_q == 2'b10) ? 3'd2 : 3'd7;
  assign bus_rdata   = (bus_rd && sel) ? {1'b0, clk_q, ipd_q, 1'b0, nowait_q, proc_mode} : 8'h00;
  assign core_rst    = !hw_rst_n || (st == ST_PULSE);
  assign ram_clear   = !hw_rst_n;
  assign mem_req     = (st == ST_VLO) || (st == ST_VHI);
  assign mem_addr    = (st == ST_VHI) ? VEC_HI : VEC_ADDR;
  assign start_valid = (st == ST_GO);
endmodule

// File: rtl/sysmode_ctrl_chk.sv
module sysmode_ctrl_chk #(
  parameter logic [15:0] REG_ADDR     = 16'h005E,
  parameter int          PULSE_CYCLES = 4
) (
  input logic        clk,
  input logic        hw_rst_n,
  input logic        mode_pin,
  input logic        bus_rd,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_rdata,
  input logic        core_rst,
  input logic        ram_clear,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [15:0] mem_addr,
  input logic        start_valid,
  input logic [1:0]  proc_mode,
  input logic        clkout_en
);
  logic [15:0] run_len;
  always_ff @(posedge clk or negedge hw_rst_n)
    if (!hw_rst_n) run_len <= '0;
    else           run_len <= core_rst ? run_len + 16'd1 : 16'd0;

  AST_RST_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!hw_rst_n) bus_rd |-> !bus_rdata[3]); // R2
  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!hw_rst_n) (!core_rst && run_len != 16'd0) |-> run_len == 16'(PULSE_CYCLES)); // R3
  AST_PIN_FORCES_MODE: assert property (@(posedge clk) disable iff (!hw_rst_n) (bus_rd && bus_addr == REG_ADDR && mode_pin) |-> bus_rdata[1]); // R4
  AST_RAM_KEPT_ON_SW_RST: assert property (@(posedge clk) disable iff (!hw_rst_n) core_rst |-> !ram_clear); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!hw_rst_n) (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R6
  AST_NO_REQ_IN_RST: assert property (@(posedge clk) disable iff (!hw_rst_n) core_rst |-> !mem_req); // R6
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!hw_rst_n) start_valid |=> !start_valid); // R7
  AST_CLKOUT_GATED: assert property (@(posedge clk) disable iff (!hw_rst_n) (proc_mode == 2'b10) |-> !clkout_en); // R8
endmodule

bind sysmode_ctrl sysmode_ctrl_chk #(.REG_ADDR(REG_ADDR), .PULSE_CYCLES(PULSE_CYCLES)) chk_i (
  .clk(clk), .hw_rst_n(hw_rst_n), .mode_pin(mode_pin), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .core_rst(core_rst), .ram_clear(ram_clear), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .start_valid(start_valid), .proc_mode(proc_mode),
  .clkout_en(clkout_en));

// File: tb/sysmode_ctrl_tb.sv
module sysmode_ctrl_tb_top;
  localparam logic [15:0] RA = 16'h005E;
  localparam int PC = 4;

  logic clk = 0, hw_rst_n = 0, mode_pin = 0, bus_wr = 0, bus_rd = 0, mem_ack = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, mem_rdata = 0;
  logic core_rst, ram_clear, mem_req, start_valid, ext_wait, clkout_en;
  logic [15:0] mem_addr, start_addr;
  logic [1:0] proc_mode;
  logic [2:0] ipd_cycles;

  always #10 clk = ~clk;

  sysmode_ctrl dut_i (.*);

  int checks = 0, errors = 0;
  logic [7:0] vlo = 8'h34, vhi = 8'h12;
  logic [7:0] ram [16];
  logic [15:0] acked [2];
  int ack_n = 0, lat = 0;
  logic [7:0] m = 0;

  always @(posedge clk) begin
    if (ram_clear) for (int i = 0; i < 16; i++) ram[i] <= 8'h00;
    if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= (mem_addr == 16'hFFFF) ? vhi : vlo;
        if (ack_n < 2) acked[ack_n] = mem_addr;
        ack_n++;
        lat = $urandom % 3;
      end else lat--;
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return {1'b0, m[6:4], 1'b0, m[2], m[1] | mode_pin, m[0]};
  endfunction
  function automatic logic [2:0] exp_ipd();
    return (m[5:4] == 2'b01) ? 3'd4 : (m[5:4] == 2'b10) ? 3'd2 : 3'd7;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a; #1; d = bus_rdata; bus_rd = 0; #1;
  endtask

  task automatic check_regs(input string tag);
    logic [7:0] d;
    logic [1:0] pm;
    rd(RA, d);
    chk(d === exp_rd(), {tag, " R1 readback"}, d, exp_rd());
    chk(d[3] === 1'b0, "R2 reset bit reads 0", d[3], 0);
    pm = {m[1] | mode_pin, m[0]};
    chk(proc_mode === pm, "R4 proc_mode", proc_mode, pm);
    chk(clkout_en === (m[6] && pm != 2'b10), "R8 clkout_en", clkout_en, m[6] && pm != 2'b10);
    chk(ipd_cycles === exp_ipd(), "R9 ipd_cycles", ipd_cycles, exp_ipd());
    chk(ext_wait === !m[2], "R10 ext_wait", ext_wait, !m[2]);
  endtask

  task automatic wait_start(input string tag);
    int n = 0;
    while (!start_valid && n < 60) begin @(negedge clk); n++; end
    chk(start_valid === 1'b1, {tag, " R7 start_valid seen"}, start_valid, 1);
    chk(start_addr === {vhi, vlo}, {tag, " R7 start_addr"}, start_addr, {vhi, vlo});
    chk(acked[0] === 16'hFFFE && acked[1] === 16'hFFFF, {tag, " R6 vector order"}, {acked[0], acked[1]}, 32'hFFFEFFFF);
    @(negedge clk);
    chk(start_valid === 1'b0, {tag, " R7 strobe one cycle"}, start_valid, 0);
  endtask

  task automatic sw_reset(input logic [7:0] d);
    int n = 0;
    logic rc = 0;
    logic [7:0] snap [16];
    for (int i = 0; i < 16; i++) begin ram[i] = 8'($urandom); snap[i] = ram[i]; end
    vlo = 8'($urandom); vhi = 8'($urandom); ack_n = 0;
    wr(RA, d | 8'h08);
    while (core_rst && n < 20) begin rc = rc | ram_clear; n++; @(negedge clk); end
    chk(n == PC, "R3 pulse length", n, PC);
    chk(rc === 1'b0, "R5 ram_clear low in sw reset", rc, 0);
    chk(mem_req === 1'b1, "R6 fetch follows pulse", mem_req, 1);
    wr(RA, 8'h71);
    m = {6'b0, mode_pin, 1'b0};
    wait_start("sw");
    for (int i = 0; i < 16; i++)
      if (ram[i] !== snap[i]) chk(0, "R5 RAM kept", ram[i], snap[i]);
    chk(1, "R5 RAM kept", 0, 0);
    check_regs("R3 R11 post-reset");
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(core_rst === 1'b1 && ram_clear === 1'b1, "R5 hw reset drives both", {core_rst, ram_clear}, 3);
    chk(mem_req === 1'b0, "R6 no fetch in reset", mem_req, 0);
    hw_rst_n = 1;
    wait_start("hw");
    check_regs("R1 reset value");
    rd(16'h005F, d);
    chk(d === 8'h00, "R1 other address reads 0", d, 0);
    wr(RA, 8'hF7); m = 8'h77; check_regs("R1 all fields");
    wr(RA, 8'h42); m = 8'h42; check_regs("R8 micro mode gate");
    wr(RA, 8'h15); m = 8'h15; check_regs("R9 ipd 01");
    mode_pin = 1; @(negedge clk); m[1] = 1;
    wr(RA, 8'h40); m = 8'h42; check_regs("R4 pin holds bit");
    sw_reset(8'hFF);
    mode_pin = 0;
    for (int i = 0; i < 150; i++) begin
      if (i % 17 == 5) begin mode_pin = ~mode_pin; @(negedge clk); if (mode_pin) m[1] = 1; end
      if (i % 25 == 24) sw_reset(8'($urandom));
      else begin
        d = 8'($urandom) & 8'hF7;
        wr(RA, d);
        m = d & 8'h77; if (mode_pin) m[1] = 1;
        check_regs("random");
      end
    end
    hw_rst_n = 0; mode_pin = 1; @(negedge clk);
    chk(ram_clear === 1'b1, "R5 hw reset clears RAM", ram_clear, 1);
    hw_rst_n = 1; ack_n = 0; m = 0;
    wait_start("hw2");
    check_regs("R4 pin after hw reset");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule